// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Front End

This block is the bus-facing front end of a parallel I/O expander. It sits on a microcontroller bus where one set of eight lines carries the low address byte and then the data byte. A separate enable signal `e_i` divides each bus cycle into two phases. While `e_i` is low, an address strobe captures the low byte as the register index. When `e_i` rises, the high address nibble is compared against a base value that software can change, and the active-low chip select is checked at the same moment. A selected cycle then either drives read data back onto the bus or collects write data, depending on the read/write line.

The register file behind this block receives three things: a register index, a one-clock write strobe with its index and data, and a read-data input. This block returns the read data to the bus and turns the bus output enable on and off. All bus inputs are sampled by the local clock `clk`, and the block finds the edges of `e_i` itself. The base nibble sits in the low bits of one internal register, at index `INIT_IDX`, and it resets to `BASE_RST` so the part can be reached before software sets it. A mode input is captured once, on the first clock after reset ends. The active-low open-drain interrupt is shown as a pull-enable output.

Top module: `mbus_slave_if`

## Requirements
- R1: While reset is applied, `ad_oe_o`, `wr_stb_o` and `irq_pull_o` are 0, and after reset the base nibble equals `BASE_RST` (default 4'h1).
- R2: Each clock edge that samples `as_i` high while `e_i` is low loads `ad_i` into the index latch. `reg_idx_o` shows the latched value from the next clock on.
- R3: At the clock edge that first sees `e_i` high, the cycle is selected only if `a_hi_i` equals the base nibble and `csn_i` is 0.
- R4: `ad_oe_o` goes to 1 one clock after the rising edge of `e_i` is sampled, and only for a selected cycle with `rwn_i` = 1. It returns to 0 in the same cycle that `e_i` goes low, with no clock in between.
- R5: While `ad_oe_o` is 1, `ad_o` equals `rd_data_i`.
- R6: A selected cycle with `rwn_i` = 0 gives exactly one `wr_stb_o` pulse, one clock wide. The pulse comes one clock after the falling edge of `e_i` is sampled. With it, `wr_idx_o` holds the latched index and `wr_data_o` holds the last `ad_i` value sampled while `e_i` was high.
- R7: An unselected cycle, where the nibble does not match or `csn_i` = 1, raises neither `ad_oe_o` nor `wr_stb_o`.
- R8: A selected write to index `INIT_IDX` (default 8'h0F) loads `wr_data_o[3:0]` into the base nibble. Later cycles are then selected on the new base and no longer on the old one.
- R9: `mode_o` takes the value of `mode_i` on the first clock after reset ends. Later changes of `mode_i` leave it unchanged.
- R10: `irq_pull_o` follows `irq_req_i` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples all bus inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| e_i | input | 1 | Bus phase enable: low for the address phase, high for the data phase |
| as_i | input | 1 | Address strobe for the low byte |
| rwn_i | input | 1 | 1 = read, 0 = write |
| csn_i | input | 1 | Active-low chip select |
| a_hi_i | input | HI_W (4) | High address nibble |
| ad_i | input | LO_W (8) | Value on the shared address/data lines |
| ad_o | output | LO_W (8) | Read data to drive onto the shared lines |
| ad_oe_o | output | 1 | Output enable for the shared lines |
| mode_i | input | 1 | Operating mode, captured once after reset |
| mode_o | output | 1 | Captured operating mode |
| reg_idx_o | output | LO_W (8) | Latched register index |
| rd_data_i | input | LO_W (8) | Read data from the register file |
| wr_stb_o | output | 1 | One-clock write strobe |
| wr_idx_o | output | LO_W (8) | Index that goes with the write strobe |
| wr_data_o | output | LO_W (8) | Data that goes with the write strobe |
| irq_req_i | input | 1 | Interrupt request from the register file |
| irq_pull_o | output | 1 | Enable that pulls the open-drain interrupt line low |

## Verification
The latencies are fixed, and the bench checks each result at the falling clock edge where it should first appear:
- `reg_idx_o`: one clock after `as_i` is sampled.
- `ad_oe_o` and `ad_o`: one clock after the rising edge of `e_i` is seen.
- `wr_stb_o`, `wr_idx_o` and `wr_data_o`: one clock after the falling edge of `e_i` is seen.
- `irq_pull_o`: one clock after its request.

The drop of `ad_oe_o` is checked one nanosecond after `e_i` falls, before any clock edge, because it must happen with no clock in between. The driver pushes each expected write into a queue. The monitor pops one entry for every strobe it sees, so a missing strobe, an extra strobe or a two-clock strobe is reported.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  // Phase of the current bus cycle as decided at the rising edge of the enable
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_state_t;
endpackage

// File: rtl/mbus_rst_sync.sv
module mbus_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int unsigned LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_i,
  input  logic            e_i,
  input  logic [LO_W-1:0] ad_i,
  output logic [LO_W-1:0] lo_addr_o
);
  logic            load_en;
  logic [LO_W-1:0] lo_addr_d, lo_addr_q;

  // Address is only valid on the shared lines during the low phase
  assign load_en = as_i & ~e_i;

  always_comb begin
    lo_addr_d = lo_addr_q;
    if (load_en) lo_addr_d = ad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_addr_q <= '0;
    else        lo_addr_q <= lo_addr_d;
  end

  assign lo_addr_o = lo_addr_q;
endmodule

// File: rtl/mbus_cfg.sv
module mbus_cfg #(
  parameter int unsigned     HI_W     = 4,
  parameter int unsigned     LO_W     = 8,
  parameter logic [HI_W-1:0] BASE_RST = 4'h1,
  parameter logic [LO_W-1:0] INIT_IDX = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic            wr_stb_i,
  input  logic [LO_W-1:0] wr_idx_i,
  input  logic [LO_W-1:0] wr_data_i,
  output logic [HI_W-1:0] base_o,
  output logic            mode_o
);
  logic [HI_W-1:0] base_d, base_q;
  logic            mode_d, mode_q;
  logic            armed_d, armed_q;
  logic            base_we;

  assign base_we = wr_stb_i & (wr_idx_i == INIT_IDX);

  always_comb begin
    base_d  = base_q;
    mode_d  = mode_q;
    armed_d = armed_q;
    if (base_we) base_d = wr_data_i[HI_W-1:0];
    // Capture mode once, on the first clock out of reset
    if (!armed_q) begin
      mode_d  = mode_i;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= BASE_RST;
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      base_q  <= base_d;
      mode_q  <= mode_d;
      armed_q <= armed_d;
    end
  end

  assign base_o = base_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbus_pkg::*;
#(
  parameter int unsigned HI_W = 4,
  parameter int unsigned LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            e_i,
  input  logic            rwn_i,
  input  logic            csn_i,
  input  logic [HI_W-1:0] a_hi_i,
  input  logic [HI_W-1:0] base_i,
  input  logic [LO_W-1:0] ad_i,
  input  logic [LO_W-1:0] lo_addr_i,
  output logic            ad_oe_o,
  output logic            wr_stb_o,
  output logic [LO_W-1:0] wr_idx_o,
  output logic [LO_W-1:0] wr_data_o
);
  cyc_state_t      st_d, st_q;
  logic            e_q;
  logic            e_rise, e_fall;
  logic            hit;
  logic            stb_d, stb_q;
  logic [LO_W-1:0] idx_d, idx_q;
  logic [LO_W-1:0] wdat_d, wdat_q;

  assign e_rise = e_i & ~e_q;
  assign e_fall = ~e_i & e_q;
  assign hit    = (a_hi_i == base_i) & ~csn_i;

  always_comb begin
    st_d = st_q;
    if (e_rise) begin
      if (hit) st_d = rwn_i ? CYC_READ : CYC_WRITE;
      else     st_d = CYC_IDLE;
    end else if (e_fall) begin
      st_d = CYC_IDLE;
    end
  end

  always_comb begin
    wdat_d = wdat_q;
    if (e_i && st_q == CYC_WRITE) wdat_d = ad_i;
    stb_d = e_fall & (st_q == CYC_WRITE);
    idx_d = idx_q;
    if (stb_d) idx_d = lo_addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CYC_IDLE;
      e_q    <= 1'b0;
      stb_q  <= 1'b0;
      idx_q  <= '0;
      wdat_q <= '0;
    end else begin
      st_q   <= st_d;
      e_q    <= e_i;
      stb_q  <= stb_d;
      idx_q  <= idx_d;
      wdat_q <= wdat_d;
    end
  end

  // Raw e_i gates the enable so it releases without waiting for a clock
  assign ad_oe_o   = e_i & (st_q == CYC_READ);
  assign wr_stb_o  = stb_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = wdat_q;
endmodule

// File: rtl/mbus_slave_if.sv
module mbus_slave_if #(
  parameter int unsigned     HI_W       = 4,
  parameter int unsigned     LO_W       = 8,
  parameter int unsigned     RST_STAGES = 2,
  parameter logic [HI_W-1:0] BASE_RST   = 4'h1,
  parameter logic [LO_W-1:0] INIT_IDX   = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            e_i,
  input  logic            as_i,
  input  logic            rwn_i,
  input  logic            csn_i,
  input  logic [HI_W-1:0] a_hi_i,
  input  logic [LO_W-1:0] ad_i,
  output logic [LO_W-1:0] ad_o,
  output logic            ad_oe_o,
  input  logic            mode_i,
  output logic            mode_o,
  output logic [LO_W-1:0] reg_idx_o,
  input  logic [LO_W-1:0] rd_data_i,
  output logic            wr_stb_o,
  output logic [LO_W-1:0] wr_idx_o,
  output logic [LO_W-1:0] wr_data_o,
  input  logic            irq_req_i,
  output logic            irq_pull_o
);
  logic            rst_sync_n;
  logic [LO_W-1:0] lo_addr;
  logic [HI_W-1:0] base;
  logic            stb;
  logic [LO_W-1:0] stb_idx, stb_data;
  logic            irq_q;

  mbus_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mbus_addr_latch #(.LO_W(LO_W)) u_lat (
    .clk(clk), .rst_n(rst_sync_n), .as_i(as_i), .e_i(e_i),
    .ad_i(ad_i), .lo_addr_o(lo_addr)
  );

  mbus_cfg #(.HI_W(HI_W), .LO_W(LO_W), .BASE_RST(BASE_RST), .INIT_IDX(INIT_IDX)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .mode_i(mode_i),
    .wr_stb_i(stb), .wr_idx_i(stb_idx), .wr_data_i(stb_data),
    .base_o(base), .mode_o(mode_o)
  );

  mbus_cycle_ctrl #(.HI_W(HI_W), .LO_W(LO_W)) u_cyc (
    .clk(clk), .rst_n(rst_sync_n), .e_i(e_i), .rwn_i(rwn_i), .csn_i(csn_i),
    .a_hi_i(a_hi_i), .base_i(base), .ad_i(ad_i), .lo_addr_i(lo_addr),
    .ad_oe_o(ad_oe_o), .wr_stb_o(stb), .wr_idx_o(stb_idx), .wr_data_o(stb_data)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_req_i;
  end

  assign ad_o       = rd_data_i;
  assign reg_idx_o  = lo_addr;
  assign wr_stb_o   = stb;
  assign wr_idx_o   = stb_idx;
  assign wr_data_o  = stb_data;
  assign irq_pull_o = irq_q;
endmodule

// File: rtl/mbus_slave_if_chk.sv
module mbus_slave_if_chk #(
  parameter int unsigned LO_W = 8
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            e_i,
  input logic            as_i,
  input logic [LO_W-1:0] ad_i,
  input logic            ad_oe_o,
  input logic            wr_stb_o,
  input logic [LO_W-1:0] reg_idx_o,
  input logic            irq_req_i,
  input logic            irq_pull_o
);
  // R1: quiet outputs while held in reset
  always @(posedge clk) begin
    if (!rst_sync_n) assert_quiet_in_reset_R1: assert (!ad_oe_o && !wr_stb_o && !irq_pull_o);
  end

  // R2: index follows a sampled address strobe in the low phase
  assert_index_capture_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(as_i) && !$past(e_i)) |-> (reg_idx_o == $past(ad_i)));

  // R4: drive enable never outside the high phase
  assert_oe_in_high_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ad_oe_o |-> e_i);

  // R6: strobe lasts a single clock
  assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_stb_o |=> !wr_stb_o);

  // R6: strobe comes after the high phase ended, never alongside a read drive
  assert_stb_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_stb_o |-> !ad_oe_o);

  // R10: interrupt pull follows request by one clock
  assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (irq_pull_o == $past(irq_req_i)));
endmodule

bind mbus_slave_if mbus_slave_if_chk #(.LO_W(LO_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .e_i(e_i), .as_i(as_i), .ad_i(ad_i),
  .ad_oe_o(ad_oe_o), .wr_stb_o(wr_stb_o), .reg_idx_o(reg_idx_o),
  .irq_req_i(irq_req_i), .irq_pull_o(irq_pull_o)
);

// File: tb/mbus_slave_if_test.sv
module mbus_slave_if_test;
  localparam int unsigned     HI_W     = 4;
  localparam int unsigned     LO_W     = 8;
  localparam logic [LO_W-1:0] INIT_IDX = 8'h0F;

  logic clk = 1'b0;
  logic rst_n, e, as_s, rwn, csn, mode, irq_req;
  logic [HI_W-1:0] a_hi;
  logic [LO_W-1:0] ad_in, rd_data;
  logic [LO_W-1:0] ad_out, reg_idx, wr_idx, wr_data;
  logic ad_oe, mode_out, wr_stb, irq_pull;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  logic [HI_W-1:0] base_m = 4'h1;
  logic [2*LO_W-1:0] exp_q[$];

  always #2 clk = ~clk;

  mbus_slave_if uut (
    .clk(clk), .rst_n(rst_n), .e_i(e), .as_i(as_s), .rwn_i(rwn), .csn_i(csn),
    .a_hi_i(a_hi), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .mode_i(mode), .mode_o(mode_out), .reg_idx_o(reg_idx), .rd_data_i(rd_data),
    .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .irq_req_i(irq_req), .irq_pull_o(irq_pull)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus cycle; expected writes go into the scoreboard queue
  task automatic bus_cycle(input logic [HI_W-1:0] hi, input logic [LO_W-1:0] lo,
                           input logic rw, input logic cs_n, input logic [LO_W-1:0] wd);
    bit sel;
    sel = (hi == base_m) && !cs_n;
    @(negedge clk); e = 0; as_s = 1; ad_in = lo; a_hi = hi; csn = cs_n; rwn = rw;
    @(negedge clk); @(negedge clk); as_s = 0;
    @(negedge clk);
    check(reg_idx == lo, "R2 index latch", reg_idx, lo);
    e = 1; ad_in = rw ? 8'hEE : wd;
    @(negedge clk);
    check(ad_oe == (sel && rw), "R3/R4/R7 drive enable", ad_oe, sel && rw);
    if (sel && rw) check(ad_out == rd_data, "R5 read data", ad_out, rd_data);
    @(negedge clk); @(negedge clk);
    if (sel && !rw) exp_q.push_back({lo, wd});
    e = 0;
    #1 check(ad_oe == 1'b0, "R4 release on fall", ad_oe, 0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    if (sel && !rw && lo == INIT_IDX) base_m = wd[HI_W-1:0];
  endtask

  // Monitor: pops the scoreboard on each strobe
  logic prev_stb = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_stb && prev_stb) check(0, "R6 strobe width", 2, 1);
      if (wr_stb) begin
        if (exp_q.size() == 0) check(0, "R7 unexpected strobe", {wr_idx, wr_data}, 0);
        else begin
          logic [2*LO_W-1:0] it;
          it = exp_q.pop_front();
          check({wr_idx, wr_data} == it, "R6 write item", {wr_idx, wr_data}, it);
        end
      end
      prev_stb <= wr_stb;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1; e = 0; as_s = 0; rwn = 1; csn = 1; mode = 1; irq_req = 0;
    a_hi = 0; ad_in = 0; rd_data = 8'h5A;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    check(!ad_oe && !wr_stb && !irq_pull, "R1 reset outputs", {ad_oe, wr_stb, irq_pull}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    mon_on = 1;
    check(mode_out == 1'b1, "R9 mode capture", mode_out, 1);
    mode = 0;
    repeat (3) @(negedge clk);
    check(mode_out == 1'b1, "R9 mode held", mode_out, 1);

    // R1/R3: default base 1 reachable
    bus_cycle(4'h1, 8'h21, 1'b1, 1'b0, 8'h00);
    rd_data = 8'hC3;
    bus_cycle(4'h1, 8'h07, 1'b1, 1'b0, 8'h00);
    // R6 writes
    bus_cycle(4'h1, 8'h33, 1'b0, 1'b0, 8'hA5);
    bus_cycle(4'h1, 8'hFF, 1'b0, 1'b0, 8'h3C);
    // R7 unselected: chip select high, nibble mismatch
    bus_cycle(4'h1, 8'h44, 1'b0, 1'b1, 8'h99);
    bus_cycle(4'h2, 8'h45, 1'b0, 1'b0, 8'h98);
    bus_cycle(4'h3, 8'h46, 1'b1, 1'b0, 8'h00);
    // R8 reprogram base to 5
    bus_cycle(4'h1, INIT_IDX, 1'b0, 1'b0, 8'hF5);
    bus_cycle(4'h1, 8'h50, 1'b0, 1'b0, 8'h11);
    bus_cycle(4'h5, 8'h51, 1'b0, 1'b0, 8'h22);
    rd_data = 8'h0D;
    bus_cycle(4'h5, 8'h52, 1'b1, 1'b0, 8'h00);
    bus_cycle(4'h1, 8'h53, 1'b1, 1'b0, 8'h00);

    // R10 interrupt follow
    @(negedge clk); irq_req = 1;
    @(negedge clk); check(irq_pull == 1'b1, "R10 irq assert", irq_pull, 1);
    irq_req = 0;
    @(negedge clk); check(irq_pull == 1'b0, "R10 irq release", irq_pull, 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 missing strobe", exp_q.size(), 0);
    check(mode_out == 1'b1, "R9 mode final", mode_out, 1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule